// File: doc/BRIEF.md
# Video Capture Active-Window Gate

This block sits between a parallel RGB pixel input and the line buffer of a capture path. On every pixel clock it tracks the position of the incoming sample. A pixel counter restarts on each rising edge of the horizontal sync. A line counter restarts on each rising edge of the vertical sync. The block raises a pixel-valid strobe only for samples inside a programmed rectangle, and it hands the sample data forward together with that strobe. Two markers help the downstream writer. One flags the first valid pixel of every valid line. The other flags the first valid pixel of the whole frame.

Software programs the rectangle through a write-only register port with three word offsets:
- 0x80 holds the line period. Bits 13:0 give the period in clocks minus one.
- 0x84 holds the horizontal window. Bits 11:0 give the start, offset by +4. Bits 27:16 give the width.
- 0x88 holds the vertical window. Bits 11:0 give the start, offset by +1. Bits 24:16 give the height.

The width is forced even and capped at 840 pixels, which is the size of the line buffer. Writes go into a staging copy. That copy becomes active at the next vertical sync rising edge, so a frame is never captured with a mixture of two settings.

Top module: `vcap_window_gate`

## Requirements
- R1: After reset, pix_valid, line_start and frame_start are low, and they stay low until a rising edge of vsync has been seen, whatever the hsync activity.
- R2: Pixel index 0 is the sample present in the clock after the one in which hsync (or vsync) is first seen high. The first valid pixel index is the 0x84 bits 11:0 value minus 4. A value of 4 or less gives index 0.
- R3: The number of valid pixels per line is the 0x84 bits 27:16 value with bit 0 cleared, capped at 840.
- R4: Line index 0 is the line that begins at a vsync rising edge. The first valid line index is the 0x88 bits 11:0 value minus 1, with 0 or 1 giving line 0. The number of valid lines is the 0x88 bits 24:16 value.
- R5: The outputs follow the input by one clock. Whenever pix_valid is high, pix_out equals the pix_in sample from the previous clock.
- R6: line_start is high together with the first valid pixel of each valid line, and only then.
- R7: frame_start is high together with the first valid pixel of the first valid line of a frame, and only then.
- R8: Register writes take effect from the next vsync rising edge. A frame already in progress keeps its old window.
- R9: If no hsync edge arrives, the pixel counter wraps after (0x80 bits 13:0 value + 1) clocks, and each wrap starts a new line. A vsync rising edge also restarts the pixel counter.
- R10: Writes to any offset other than 0x80, 0x84 or 0x88, and the bits of a register outside the fields named above, have no effect.
- R11: An hsync rising edge restarts the pixel counter even in the middle of a programmed line period, and it starts a new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| pix_in | input | DATA_W | Incoming pixel sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte offset |
| wr_data | input | 32 | Register write data |
| pix_out | output | DATA_W | Pixel forwarded with the strobe |
| pix_valid | output | 1 | Sample lies inside the window |
| line_start | output | 1 | First valid pixel of a line |
| frame_start | output | 1 | First valid pixel of a frame |

## Verification
A wrong pixel or line counter does not stay hidden. On the next valid line, pix_valid starts or stops at the wrong clock, or it disappears. The fault therefore shows within one line period, and the per-clock comparison catches the first mismatched strobe. A staging or active register that loads at the wrong moment shows up as a window that changes shape mid-frame, or that fails to change after the next vsync edge. A clamp or offset error shows as a wrong count of valid pixels per frame. Each of these is compared against a count that the bench works out itself.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  localparam int HC_W   = 14;
  localparam int HST_W  = 12;
  localparam int HEN_W  = 12;
  localparam int VST_W  = 12;
  localparam int VEN_W  = 9;
  localparam int HCNT_W = HC_W;
  localparam int VCNT_W = VST_W + 1;

  localparam int HEN_LSB = 16;
  localparam int VEN_LSB = 16;

  localparam int unsigned HST_OFS = 4;
  localparam int unsigned VST_OFS = 1;

  localparam int OFS_CYC  = 'h80;
  localparam int OFS_HWIN = 'h84;
  localparam int OFS_VWIN = 'h88;

  typedef struct packed {
    logic [HC_W-1:0]  cyc;
    logic [HST_W-1:0] hst;
    logic [HEN_W-1:0] hen;
    logic [VST_W-1:0] vst;
    logic [VEN_W-1:0] ven;
  } cfg_t;

  typedef struct packed {
    logic [HCNT_W-1:0] hs;
    logic [HCNT_W-1:0] he;
    logic [VCNT_W-1:0] vs;
    logic [VCNT_W-1:0] ve;
  } win_t;

  function automatic int unsigned sub_floor(int unsigned raw, int unsigned ofs);
    return (raw > ofs) ? raw - ofs : 0;
  endfunction

  function automatic int unsigned even_cap(int unsigned raw, int unsigned cap);
    int unsigned w;
    w = raw & ~32'd1;
    return (w > cap) ? cap : w;
  endfunction

  function automatic win_t decode_win(cfg_t c, int unsigned cap);
    win_t r;
    int unsigned hs, wd, vs;
    hs = sub_floor(32'(c.hst), HST_OFS);
    wd = even_cap(32'(c.hen), cap);
    vs = sub_floor(32'(c.vst), VST_OFS);
    r.hs = HCNT_W'(hs);
    r.he = HCNT_W'(hs + wd);
    r.vs = VCNT_W'(vs);
    r.ve = VCNT_W'(vs + 32'(c.ven));
    return r;
  endfunction

endpackage

// File: rtl/vcap_rise_det.sv
module vcap_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/vcap_cfg_regs.sv
module vcap_cfg_regs
  import vcap_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LINE_MAX = 840
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              load,
  output win_t              win_act,
  output logic [HC_W-1:0]   cyc_act
);
  localparam logic [ADDR_W-1:0] A_CYC  = ADDR_W'(OFS_CYC);
  localparam logic [ADDR_W-1:0] A_HWIN = ADDR_W'(OFS_HWIN);
  localparam logic [ADDR_W-1:0] A_VWIN = ADDR_W'(OFS_VWIN);

  cfg_t stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg     <= '0;
      stg.cyc <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        A_CYC:  stg.cyc <= wr_data[HC_W-1:0];
        A_HWIN: begin
          stg.hst <= wr_data[HST_W-1:0];
          stg.hen <= wr_data[HEN_LSB +: HEN_W];
        end
        A_VWIN: begin
          stg.vst <= wr_data[VST_W-1:0];
          stg.ven <= wr_data[VEN_LSB +: VEN_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_act <= '0;
      cyc_act <= '1;
    end else if (load) begin
      win_act <= decode_win(stg, LINE_MAX);
      cyc_act <= stg.cyc;
    end
  end
endmodule

// File: rtl/vcap_timing.sv
module vcap_timing
  import vcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_edge,
  input  logic              vs_edge,
  input  logic [HC_W-1:0]   cyc_act,
  output logic [HCNT_W-1:0] hcnt,
  output logic [VCNT_W-1:0] vcnt,
  output logic              armed
);
  logic wrap, line_bnd;

  assign wrap     = (hcnt >= cyc_act);
  assign line_bnd = hs_edge | wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) hcnt <= '0;
    else if (hs_edge || vs_edge || wrap) hcnt <= '0;
    else hcnt <= hcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcnt  <= '0;
      armed <= 1'b0;
    end else if (vs_edge) begin
      vcnt  <= '0;
      armed <= 1'b1;
    end else if (line_bnd && (vcnt != '1)) begin
      vcnt <= vcnt + 1'b1;
    end
  end
endmodule

// File: rtl/vcap_win_gate.sv
module vcap_win_gate
  import vcap_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HCNT_W-1:0] hcnt,
  input  logic [VCNT_W-1:0] vcnt,
  input  logic              armed,
  input  win_t              win,
  input  logic [DATA_W-1:0] pix_in,
  output logic [DATA_W-1:0] pix_out,
  output logic              pix_valid,
  output logic              line_start,
  output logic              frame_start
);
  logic in_h, in_v, hit, first_px, first_ln;

  assign in_h     = (hcnt >= win.hs) && (hcnt < win.he);
  assign in_v     = (vcnt >= win.vs) && (vcnt < win.ve);
  assign hit      = armed && in_h && in_v;
  assign first_px = hit && (hcnt == win.hs);
  assign first_ln = first_px && (vcnt == win.vs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid   <= 1'b0;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      pix_valid   <= hit;
      line_start  <= first_px;
      frame_start <= first_ln;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pix_out <= '0;
    else if (hit) pix_out <= pix_in;
  end
endmodule

// File: rtl/vcap_window_gate.sv
module vcap_window_gate
  import vcap_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int ADDR_W   = 8,
  parameter int LINE_MAX = 840
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [DATA_W-1:0] pix_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [DATA_W-1:0] pix_out,
  output logic              pix_valid,
  output logic              line_start,
  output logic              frame_start
);
  logic [1:0]        rise;
  logic              hs_edge, vs_edge, armed;
  logic [HCNT_W-1:0] hcnt;
  logic [VCNT_W-1:0] vcnt;
  logic [HC_W-1:0]   cyc_act;
  win_t              win_act;

  vcap_rise_det #(.N(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl({vsync, hsync}), .rise(rise)
  );
  assign hs_edge = rise[0];
  assign vs_edge = rise[1];

  vcap_cfg_regs #(.ADDR_W(ADDR_W), .LINE_MAX(LINE_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(vs_edge), .win_act(win_act), .cyc_act(cyc_act)
  );

  vcap_timing u_tim (
    .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge), .vs_edge(vs_edge),
    .cyc_act(cyc_act), .hcnt(hcnt), .vcnt(vcnt), .armed(armed)
  );

  vcap_win_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .armed(armed),
    .win(win_act), .pix_in(pix_in), .pix_out(pix_out), .pix_valid(pix_valid),
    .line_start(line_start), .frame_start(frame_start)
  );
endmodule

// File: rtl/vcap_window_gate_chk.sv
module vcap_window_gate_chk
  import vcap_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int LINE_MAX = 840
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] pix_in,
  input logic [DATA_W-1:0] pix_out,
  input logic              pix_valid,
  input logic              line_start,
  input logic              frame_start,
  input logic              hs_edge,
  input logic              vs_edge,
  input logic              armed,
  input logic [HCNT_W-1:0] hcnt,
  input logic [HC_W-1:0]   cyc_act,
  input win_t              win_act
);
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)          run <= '0;
    else if (line_start) run <= 16'd1;
    else if (pix_valid)  run <= run + 16'd1;
    else                 run <= '0;
  end

  p_idle_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!armed) |-> !pix_valid);

  p_run_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 16'(LINE_MAX));

  p_data_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_out == $past(pix_in)));

  p_ls_has_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> pix_valid);

  p_fs_has_ls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start);

  p_win_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> ($stable(win_act) && $stable(cyc_act)));

  p_hcnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cyc_act) && $past(hcnt <= cyc_act)) |-> (hcnt <= cyc_act));

  p_hs_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> (hcnt == '0));
endmodule

bind vcap_window_gate vcap_window_gate_chk #(.DATA_W(DATA_W), .LINE_MAX(LINE_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_out(pix_out),
  .pix_valid(pix_valid), .line_start(line_start), .frame_start(frame_start),
  .hs_edge(hs_edge), .vs_edge(vs_edge), .armed(armed), .hcnt(hcnt),
  .cyc_act(cyc_act), .win_act(win_act)
);

// File: tb/vcap_window_gate_tb_top.sv
module vcap_window_gate_tb_top;
  localparam int DW  = 24;
  localparam int CAP = 840;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsync = 1'b0, vsync = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] pix_in = '0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [DW-1:0] pix_out;
  logic          pix_valid, line_start, frame_start;

  always #10 clk = ~clk;

  vcap_window_gate #(.DATA_W(DW), .ADDR_W(8), .LINE_MAX(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .pix_in(pix_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pix_out(pix_out),
    .pix_valid(pix_valid), .line_start(line_start), .frame_start(frame_start)
  );

  int    n_vec = 0, n_bad = 0;
  string tag = "R1";

  // bench model: staging, active, position
  int unsigned s_cyc = 16383, s_hst = 0, s_hen = 0, s_vst = 0, s_ven = 0;
  int unsigned a_cyc = 16383, a_hst = 0, a_hen = 0, a_vst = 0, a_ven = 0;
  int unsigned bp = 0, bl = 0;
  bit          barm = 0, prev_h = 0, prev_v = 0;
  bit          have_exp = 0, e_valid = 0, e_ls = 0, e_fs = 0;
  logic [DW-1:0] e_data = '0;
  int unsigned seen_valid = 0;

  function automatic int unsigned b_hstart(int unsigned v);
    if (v <= 4) return 0;
    return v - 4;
  endfunction

  function automatic int unsigned b_width(int unsigned v);
    int unsigned w;
    w = v - (v % 2);
    if (w > CAP) w = CAP;
    return w;
  endfunction

  function automatic int unsigned b_vstart(int unsigned v);
    if (v == 0) return 0;
    return v - 1;
  endfunction

  task automatic chk(string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(bit hs, bit vs, bit we, logic [7:0] a, logic [31:0] d);
    logic [DW-1:0] px;
    int unsigned   h0, w, v0;
    bit            inh, inv, rh, rv, bnd;
    @(negedge clk);
    if (have_exp) begin
      chk("pix_valid", pix_valid, e_valid);
      chk("line_start R6", line_start, e_ls);
      chk("frame_start R7", frame_start, e_fs);
      if (e_valid) chk("pix_out R5", pix_out, e_data);
      if (pix_valid) seen_valid++;
    end
    px = DW'($urandom);
    hsync = hs; vsync = vs; pix_in = px;
    wr_en = we; wr_addr = a; wr_data = d;
    h0  = b_hstart(a_hst);
    w   = b_width(a_hen);
    v0  = b_vstart(a_vst);
    inh = (bp >= h0) && (bp < h0 + w);
    inv = (bl >= v0) && (bl < v0 + a_ven);
    e_valid = barm && inh && inv;
    e_ls    = e_valid && (bp == h0);
    e_fs    = e_ls && (bl == v0);
    if (e_valid) e_data = px;
    have_exp = 1;
    rh  = hs && !prev_h;
    rv  = vs && !prev_v;
    bnd = rh || (bp >= a_cyc);
    if (rh || rv || bp >= a_cyc) bp = 0; else bp++;
    if (rv) begin
      bl = 0; barm = 1;
      a_cyc = s_cyc; a_hst = s_hst; a_hen = s_hen; a_vst = s_vst; a_ven = s_ven;
    end else if (bnd && bl < 8191) bl++;
    if (we) begin
      case (a)
        8'h80: s_cyc = d[13:0];
        8'h84: begin s_hst = d[11:0]; s_hen = d[27:16]; end
        8'h88: begin s_vst = d[11:0]; s_ven = d[24:16]; end
        default: ;
      endcase
    end
    prev_h = hs; prev_v = vs;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    tick(0, 0, 1, a, d);
  endtask

  task automatic cfg(int unsigned cyc, int unsigned hst, int unsigned hen,
                     int unsigned vst, int unsigned ven);
    wr(8'h80, 32'(cyc));
    wr(8'h84, (32'(hen) << 16) | 32'(hst));
    wr(8'h88, (32'(ven) << 16) | 32'(vst));
  endtask

  task automatic frame(int lines, int hper, bit use_h, bit use_v, bit rnd);
    for (int li = 0; li < lines; li++) begin
      int per;
      per = rnd ? 6 + int'($urandom % 55) : hper;
      for (int c = 0; c < per; c++)
        tick(use_h && c < 2, use_v && li == 0 && c < 2, 0, 8'h00, 32'h0);
    end
  endtask

  task automatic count_check(int unsigned exp);
    tick(0, 0, 0, 8'h00, 32'h0);
    chk("valid pixels per frame", seen_valid, exp);
    seen_valid = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("reset pix_valid R1", pix_valid, 0);
    chk("reset line_start R1", line_start, 0);
    chk("reset frame_start R1", frame_start, 0);
    rst_n = 1'b1;

    // R1: hsync activity without vsync yields nothing
    tag = "R1";
    cfg(30, 4, 10, 1, 5);
    seen_valid = 0;
    frame(3, 20, 1, 0, 0);
    count_check(0);

    // R2/R3/R4: basic window, start 6, width 8, lines 2..4
    tag = "R4";
    cfg(40, 10, 8, 3, 3);
    seen_valid = 0;
    frame(8, 30, 1, 1, 0);
    count_check(24);

    // R2: start values at or below the offset clamp to zero
    tag = "R2";
    cfg(40, 3, 4, 0, 2);
    seen_valid = 0;
    frame(4, 20, 1, 1, 0);
    count_check(8);

    // R3: odd width loses bit 0
    tag = "R3";
    cfg(40, 4, 11, 1, 1);
    seen_valid = 0;
    frame(2, 30, 1, 1, 0);
    count_check(10);

    // R3: width beyond the line buffer clamps to 840
    cfg(2000, 4, 2000, 1, 1);
    seen_valid = 0;
    frame(2, 900, 1, 1, 0);
    count_check(840);

    // R8: mid-frame write waits for the next vsync edge
    tag = "R8";
    cfg(100, 4, 6, 1, 8);
    seen_valid = 0;
    frame(2, 20, 1, 1, 0);
    wr(8'h84, (32'd2 << 16) | 32'd4);
    frame(2, 20, 1, 0, 0);
    count_check(24);
    frame(2, 20, 1, 1, 0);
    count_check(4);

    // R9: no hsync, period = value + 1
    tag = "R9";
    cfg(19, 6, 4, 3, 2);
    seen_valid = 0;
    frame(6, 20, 0, 1, 0);
    count_check(8);

    // R10: reserved bits and unknown offsets are ignored
    tag = "R10";
    wr(8'h80, 32'hFFFF_C000 | 32'd30);
    wr(8'h84, 32'hF008_F006);
    wr(8'h88, 32'hFE01_F001);
    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'h90, 32'h0000_0000);
    seen_valid = 0;
    frame(2, 25, 1, 1, 0);
    count_check(8);

    // R11: random windows and irregular hsync spacing
    tag = "R11";
    for (int f = 0; f < 30; f++) begin
      cfg(10 + $urandom % 71, $urandom % 21, $urandom % 31,
          $urandom % 6, $urandom % 7);
      frame(3 + int'($urandom % 6), 0, ($urandom % 5) != 0, 1, 1);
    end
    tick(0, 0, 0, 8'h00, 32'h0);
    finish_run();
  end
endmodule